// File: doc/BRIEF.md
# Multi-Mode Timer Output Compare Channel

This block is one output-compare channel. It holds two free-running period timers and drives a single output pin from a primary and a secondary compare value. Each timer counts from zero up to its own period value and then returns to zero. A select field in the control register picks which timer serves as the time base.

A 3-bit mode field sets the waveform. The choices are disabled, active-low one-shot, active-high one-shot, toggle, delayed one-shot and continuous pulse. Writing the mode places the pin at its initial level for that mode. After that, compare matches move the pin. A sticky interrupt flag records the edges that the selected mode counts, and software clears it with a strobe.

An idle-stop control lets a chip-level idle signal freeze the channel. While frozen, the output is held at the mode's initial level. Software reaches every register through a simple single-cycle write port.

Top module: `ocmp_channel`

## Requirements
- R1: After reset the output is 0, the output-enable is 0, the interrupt flag is 0, both timers are 0 and both periods are all ones.
- R2: Writes take effect at the clock edge where `wr_en` is high. Register address 0 is control: bits [2:0] mode, bit 3 timer select, bit 4 idle-stop. Address 1 is the primary compare value, address 2 the secondary compare value, address 3 the period of timer 0 and address 4 the period of timer 1. Each timer steps by one per clock and returns to 0 in the cycle after it reaches its period. The mode logic evaluates the selected timer's present count at each edge, so a match shows on the pin one cycle after the timer holds the matching value.
- R3: Mode codes 000, 110 and 111 deassert `oc_oe`, and the pin level is retained unchanged.
- R4: Mode 001 (active-low one-shot) drives the output low when written. The first primary match drives it high and sets the flag.
- R5: Mode 010 (active-high one-shot) drives the output high when written. The first primary match drives it low and sets the flag.
- R6: Mode 011 (toggle) keeps the present level when written. Every primary match inverts the output and sets the flag.
- R7: Mode 100 (delayed one-shot) drives the output low when written. A primary match raises it, and a later secondary match lowers it and sets the flag. After that falling edge the output does not change again until the control register is rewritten.
- R8: Mode 101 (continuous pulse) behaves like R7 but repeats the pulse in every timer period. Each falling edge sets the flag.
- R9: Every control write re-arms the channel and reapplies the initial level, including a write of the mode already in force. No compare match is applied on the edge of a control write.
- R10: A primary value of 0 does not match on the zero count that follows a control write. It matches only after the selected timer has reached its period once.
- R11: With idle-stop set and `idle_i` high, an active mode performs no compare and holds the output at its initial level. With idle-stop clear, `idle_i` has no effect.
- R12: The flag stays set until a `flag_clr` strobe. A compare event on the same edge as the strobe takes priority. Level changes at mode entry never set the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 16 | Register write data |
| idle_i | input | 1 | Chip idle indication |
| flag_clr | input | 1 | Interrupt flag clear strobe |
| oc_out | output | 1 | Compare output level |
| oc_oe | output | 1 | Output-enable, high in modes 001 to 101 |
| irq_flag | output | 1 | Sticky interrupt flag |

## Verification
Each one-shot mode is run once and then retriggered. The retrigger separates a real re-arm from a channel that stays done. Toggle mode is entered after an active-high one-shot and a disable, which shows that the level held through mode 000 carries into toggle. Delayed one-shot and continuous pulse are run with the same kind of compare values on different timers: the first must stay quiet after one pulse, the second must pulse every period, and the slot on the other timer exercises the select field. A zero primary written exactly at the timer's top count, and idle assertions with idle-stop set and then clear, exercise the suppression and freeze paths.

// File: rtl/ocmp_pkg.sv
package ocmp_pkg;
   localparam int ADDR_W = 3;
   localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
   localparam logic [ADDR_W-1:0] A_PRI  = 3'd1;
   localparam logic [ADDR_W-1:0] A_SEC  = 3'd2;
   localparam int                A_PER0 = 3;

   typedef enum logic [2:0] {
      OC_OFF   = 3'd0,
      OC_LOW1  = 3'd1,
      OC_HIGH1 = 3'd2,
      OC_TGL   = 3'd3,
      OC_DLY1  = 3'd4,
      OC_CONT  = 3'd5,
      OC_RSV6  = 3'd6,
      OC_RSV7  = 3'd7
   } oc_mode_e;

   function automatic logic mode_live(input oc_mode_e m);
      return (m inside {OC_LOW1, OC_HIGH1, OC_TGL, OC_DLY1, OC_CONT});
   endfunction

   // level the pin takes on mode entry or while idle-frozen
   function automatic logic entry_level(input oc_mode_e m, input logic cur);
      case (m)
         OC_LOW1, OC_DLY1, OC_CONT: return 1'b0;
         OC_HIGH1:                  return 1'b1;
         default:                   return cur;
      endcase
   endfunction
endpackage

// File: rtl/ocmp_timer.sv
module ocmp_timer
   import ocmp_pkg::*;
#(
   parameter int                W          = 16,
   parameter logic [W-1:0]      PERIOD_RST = '1,
   parameter logic [ADDR_W-1:0] MY_ADDR    = 3'd3
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [W-1:0]      wr_data,
   output logic [W-1:0]      cnt,
   output logic              wrap
);
   logic [W-1:0] per_q;

   assign wrap = (cnt >= per_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt   <= '0;
         per_q <= PERIOD_RST;
      end else begin
         cnt <= wrap ? '0 : cnt + 1'b1;
         if (wr_en && wr_addr == MY_ADDR) per_q <= wr_data;
      end
   end
endmodule

// File: rtl/ocmp_core.sv
module ocmp_core
   import ocmp_pkg::*;
#(
   parameter int W = 16
)(
   input  logic         clk,
   input  logic         rst_n,
   input  logic         ctrl_wr,
   input  logic [2:0]   new_mode,
   input  logic         stop_req,
   input  logic [W-1:0] tmr,
   input  logic         wrap,
   input  logic [W-1:0] pri,
   input  logic [W-1:0] sec,
   input  logic         flag_clr,
   output logic [2:0]   mode_o,
   output logic         out_o,
   output logic         flag_o
);
   oc_mode_e mode_q;
   logic     out_q, flag_q, done_q, hold_q;
   logic     out_n, done_n, evt;
   logic     live, pri_hit, sec_hit;

   assign live    = mode_live(mode_q);
   assign pri_hit = (tmr == pri) && !((pri == '0) && hold_q);
   assign sec_hit = (tmr == sec);

   always_comb begin
      out_n  = out_q;
      done_n = done_q;
      evt    = 1'b0;
      if (live && stop_req) begin
         out_n = entry_level(mode_q, out_q);
      end else if (live) begin
         case (mode_q)
            OC_LOW1: if (!done_q && pri_hit) begin
               out_n = 1'b1; done_n = 1'b1; evt = 1'b1;
            end
            OC_HIGH1: if (!done_q && pri_hit) begin
               out_n = 1'b0; done_n = 1'b1; evt = 1'b1;
            end
            OC_TGL: if (pri_hit) begin
               out_n = ~out_q; evt = 1'b1;
            end
            OC_DLY1, OC_CONT: if (!done_q) begin
               if (!out_q && pri_hit) out_n = 1'b1;
               else if (out_q && sec_hit) begin
                  out_n  = 1'b0;
                  evt    = 1'b1;
                  done_n = (mode_q == OC_DLY1);
               end
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q <= OC_OFF;
         out_q  <= 1'b0;
         done_q <= 1'b0;
         hold_q <= 1'b1;
         flag_q <= 1'b0;
      end else begin
         if (ctrl_wr) begin
            mode_q <= oc_mode_e'(new_mode);
            out_q  <= entry_level(oc_mode_e'(new_mode), out_q);
            done_q <= 1'b0;
            hold_q <= 1'b1;
         end else begin
            out_q  <= out_n;
            done_q <= done_n;
            if (wrap) hold_q <= 1'b0;
         end
         if (evt && !ctrl_wr) flag_q <= 1'b1;
         else if (flag_clr)   flag_q <= 1'b0;
      end
   end

   assign mode_o = mode_q;
   assign out_o  = out_q;
   assign flag_o = flag_q;
endmodule

// File: rtl/ocmp_channel.sv
module ocmp_channel
   import ocmp_pkg::*;
#(
   parameter int           W          = 16,
   parameter int           NTMR       = 2,
   parameter logic [W-1:0] PERIOD_RST = '1
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [W-1:0]      wr_data,
   input  logic              idle_i,
   input  logic              flag_clr,
   output logic              oc_out,
   output logic              oc_oe,
   output logic              irq_flag
);
   localparam int TSW       = $clog2(NTMR);
   localparam int TSEL_LSB  = 3;
   localparam int ISTOP_BIT = TSEL_LSB + TSW;

   if (W < 8) begin : g_bad_w
      $error("ocmp_channel: W must be at least 8");
   end
   if (NTMR != 2 && NTMR != 4) begin : g_bad_ntmr
      $error("ocmp_channel: NTMR must be 2 or 4");
   end

   logic [W-1:0]   pri_q, sec_q;
   logic [TSW-1:0] tsel_q;
   logic           idle_stop_q;
   logic           ctrl_wr;
   logic [W-1:0]   cnt_v [NTMR];
   logic [NTMR-1:0] wrap_v;
   logic [2:0]     mode_w;

   assign ctrl_wr = wr_en && (wr_addr == A_CTRL);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pri_q       <= '0;
         sec_q       <= '0;
         tsel_q      <= '0;
         idle_stop_q <= 1'b0;
      end else if (wr_en) begin
         if (wr_addr == A_PRI) pri_q <= wr_data;
         if (wr_addr == A_SEC) sec_q <= wr_data;
         if (wr_addr == A_CTRL) begin
            tsel_q      <= wr_data[TSEL_LSB +: TSW];
            idle_stop_q <= wr_data[ISTOP_BIT];
         end
      end
   end

   for (genvar g = 0; g < NTMR; g++) begin : g_tmr
      ocmp_timer #(
         .W(W), .PERIOD_RST(PERIOD_RST),
         .MY_ADDR(ADDR_W'(A_PER0 + g))
      ) u_tmr (
         .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
         .wr_data(wr_data), .cnt(cnt_v[g]), .wrap(wrap_v[g])
      );
   end

   ocmp_core #(.W(W)) u_core (
      .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .new_mode(wr_data[2:0]),
      .stop_req(idle_stop_q && idle_i), .tmr(cnt_v[tsel_q]),
      .wrap(wrap_v[tsel_q]), .pri(pri_q), .sec(sec_q), .flag_clr(flag_clr),
      .mode_o(mode_w), .out_o(oc_out), .flag_o(irq_flag)
   );

   assign oc_oe = mode_live(oc_mode_e'(mode_w));
endmodule

// File: rtl/ocmp_chk.sv
module ocmp_chk #(
   parameter int W = 16
)(
   input logic         clk,
   input logic         rst_n,
   input logic         wr_en,
   input logic [2:0]   wr_addr,
   input logic [W-1:0] wr_data,
   input logic         idle_i,
   input logic         flag_clr,
   input logic         oc_out,
   input logic         oc_oe,
   input logic         irq_flag,
   input logic [2:0]   mode,
   input logic         istop
);
   logic cw;
   assign cw = wr_en && (wr_addr == 3'd0);

   a_r3_off_no_oe: assert property (@(posedge clk) disable iff (!rst_n)
      (cw && (wr_data[2:0] == 3'd0 || wr_data[2:1] == 2'b11)) |=> !oc_oe);

   a_r4_entry_low: assert property (@(posedge clk) disable iff (!rst_n)
      (cw && wr_data[2:0] == 3'd1) |=> (!oc_out && oc_oe));

   a_r5_entry_high: assert property (@(posedge clk) disable iff (!rst_n)
      (cw && wr_data[2:0] == 3'd2) |=> oc_out);

   a_r6_toggle_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      (cw && wr_data[2:0] == 3'd3) |=> $stable(oc_out));

   a_r7_fall_flags: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(oc_out) && ($past(mode) == 3'd4 || $past(mode) == 3'd5)
       && !$past(cw) && !$past(istop && idle_i)) |-> irq_flag);

   a_r11_idle_freeze: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 3'd5 && istop && idle_i && !cw) |=> !oc_out);

   a_r12_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_flag && !flag_clr) |=> irq_flag);

   a_r12_set_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_flag) |-> (oc_out != $past(oc_out)));
endmodule

bind ocmp_channel ocmp_chk #(.W(W)) chk_i (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
   .wr_data(wr_data), .idle_i(idle_i), .flag_clr(flag_clr),
   .oc_out(oc_out), .oc_oe(oc_oe), .irq_flag(irq_flag),
   .mode(mode_w), .istop(idle_stop_q)
);

// File: tb/ocmp_channel_tb.sv
`timescale 1ns/1ps
module ocmp_channel_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_addr = '0;
   logic [15:0] wr_data = '0;
   logic        idle_i = 1'b0;
   logic        flag_clr = 1'b0;
   logic        oc_out, oc_oe, irq_flag;

   int    checks = 0;
   int    errors = 0;
   string cur_req = "R1";
   bit    cmp_on = 1'b0;

   always #10 clk = ~clk;

   ocmp_channel dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .idle_i(idle_i), .flag_clr(flag_clr),
      .oc_out(oc_out), .oc_oe(oc_oe), .irq_flag(irq_flag)
   );

   // behavioural reference
   logic [15:0] m_tmr [2];
   logic [15:0] m_per [2];
   logic [15:0] m_pri, m_sec;
   int          m_mode;
   int          m_tsel;
   bit          m_istop, m_out, m_flag, m_done, m_hold;

   function automatic bit start_lvl(int md, bit cur);
      if (md == 1 || md == 4 || md == 5) return 1'b0;
      if (md == 2) return 1'b1;
      return cur;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_tmr[0] = 0; m_tmr[1] = 0; m_per[0] = 16'hFFFF; m_per[1] = 16'hFFFF;
         m_pri = 0; m_sec = 0; m_mode = 0; m_tsel = 0; m_istop = 0;
         m_out = 0; m_flag = 0; m_done = 0; m_hold = 1;
      end else begin
         logic [15:0] t;
         bit wrapped, ev, pm, sm, live;
         t       = m_tmr[m_tsel];
         wrapped = (t >= m_per[m_tsel]);
         ev      = 0;
         live    = (m_mode >= 1 && m_mode <= 5);
         if (wr_en && wr_addr == 0) begin
            m_mode = int'(wr_data[2:0]);
            m_out  = start_lvl(m_mode, m_out);
            m_done = 0; m_hold = 1;
            m_tsel = int'(wr_data[3]); m_istop = wr_data[4];
         end else begin
            pm = (t == m_pri) && !(m_pri == 0 && m_hold);
            sm = (t == m_sec);
            if (live && m_istop && idle_i) m_out = start_lvl(m_mode, m_out);
            else if (live) begin
               if ((m_mode == 1 || m_mode == 2) && !m_done && pm) begin
                  m_out = (m_mode == 1); m_done = 1; ev = 1;
               end else if (m_mode == 3 && pm) begin
                  m_out = !m_out; ev = 1;
               end else if ((m_mode == 4 || m_mode == 5) && !m_done) begin
                  if (!m_out && pm) m_out = 1;
                  else if (m_out && sm) begin
                     m_out = 0; ev = 1; m_done = (m_mode == 4);
                  end
               end
            end
            if (wrapped) m_hold = 0;
         end
         if (ev) m_flag = 1; else if (flag_clr) m_flag = 0;
         for (int i = 0; i < 2; i++)
            m_tmr[i] = (m_tmr[i] >= m_per[i]) ? 16'd0 : m_tmr[i] + 16'd1;
         if (wr_en && wr_addr == 1) m_pri = wr_data;
         if (wr_en && wr_addr == 2) m_sec = wr_data;
         if (wr_en && wr_addr == 3) m_per[0] = wr_data;
         if (wr_en && wr_addr == 4) m_per[1] = wr_data;
      end
   end

   // every-cycle comparison, away from the active edge
   always @(negedge clk) begin
      if (cmp_on) begin
         bit exp_oe;
         exp_oe = (m_mode >= 1 && m_mode <= 5);
         checks++;
         if (oc_out !== m_out || oc_oe !== exp_oe || irq_flag !== m_flag) begin
            errors++;
            $display("FAIL %s cycle compare: out/oe/flag=%b%b%b expected %b%b%b",
                     cur_req, oc_out, oc_oe, irq_flag, m_out, exp_oe, m_flag);
         end
      end
   end

   task automatic chk(input logic act, input logic exp, input string req, input string what);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [15:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic clr();
      flag_clr = 1'b1;
      @(negedge clk);
      flag_clr = 1'b0;
   endtask

   task automatic idle_wait(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      cmp_on = 1'b1;
      cur_req = "R1";
      chk(oc_out, 1'b0, "R1", "reset out");
      chk(oc_oe, 1'b0, "R1", "reset oe");
      chk(irq_flag, 1'b0, "R1", "reset flag");

      cur_req = "R2";
      wr(3'd3, 16'd19);
      wr(3'd4, 16'd9);

      cur_req = "R4";
      wr(3'd1, 16'd5);
      wr(3'd0, 16'h0001);
      chk(oc_out, 1'b0, "R4", "entry low");
      chk(oc_oe, 1'b1, "R4", "entry oe");
      idle_wait(25);
      chk(oc_out, 1'b1, "R4", "high after match");
      chk(irq_flag, 1'b1, "R4", "flag on rise");

      cur_req = "R12";
      idle_wait(3);
      chk(irq_flag, 1'b1, "R12", "flag sticky");
      clr();
      chk(irq_flag, 1'b0, "R12", "flag cleared");

      cur_req = "R9";
      wr(3'd0, 16'h0001);
      chk(oc_out, 1'b0, "R9", "retrigger low");
      idle_wait(25);
      chk(oc_out, 1'b1, "R9", "retriggered pulse");

      cur_req = "R5";
      clr();
      wr(3'd1, 16'd3);
      wr(3'd0, 16'h0002);
      chk(oc_out, 1'b1, "R5", "entry high");
      idle_wait(25);
      chk(oc_out, 1'b0, "R5", "low after match");
      chk(irq_flag, 1'b1, "R5", "flag on fall");

      cur_req = "R3";
      clr();
      wr(3'd0, 16'h0000);
      chk(oc_oe, 1'b0, "R3", "disabled oe");
      chk(oc_out, 1'b0, "R3", "level kept low");
      wr(3'd0, 16'h0002);
      wr(3'd0, 16'h0000);
      chk(oc_out, 1'b1, "R3", "level kept high");

      cur_req = "R6";
      wr(3'd1, 16'd4);
      wr(3'd0, 16'h0003);
      chk(oc_out, 1'b1, "R6", "toggle keeps level");
      chk(oc_oe, 1'b1, "R6", "toggle oe");
      idle_wait(50);
      chk(irq_flag, 1'b1, "R6", "toggle flag");

      cur_req = "R3";
      wr(3'd0, 16'h0006);
      chk(oc_oe, 1'b0, "R3", "reserved code oe");

      cur_req = "R7";
      clr();
      wr(3'd1, 16'd4);
      wr(3'd2, 16'd8);
      wr(3'd0, 16'h0004);
      chk(oc_out, 1'b0, "R7", "entry low");
      idle_wait(60);
      chk(oc_out, 1'b0, "R7", "after pulse");
      chk(irq_flag, 1'b1, "R7", "flag on fall");
      clr();
      idle_wait(25);
      chk(irq_flag, 1'b0, "R7", "no second pulse");

      cur_req = "R8";
      wr(3'd1, 16'd2);
      wr(3'd2, 16'd6);
      wr(3'd0, 16'h000D);
      idle_wait(12);
      clr();
      idle_wait(12);
      chk(irq_flag, 1'b1, "R8", "pulse repeats");

      cur_req = "R11";
      wr(3'd0, 16'h001D);
      idle_i = 1'b1;
      idle_wait(15);
      chk(oc_out, 1'b0, "R11", "frozen low");
      idle_i = 1'b0;
      idle_wait(20);
      wr(3'd0, 16'h000D);
      clr();
      idle_i = 1'b1;
      idle_wait(12);
      chk(irq_flag, 1'b1, "R11", "runs without stop bit");
      idle_i = 1'b0;

      cur_req = "R10";
      clr();
      wr(3'd1, 16'd0);
      while (m_tmr[0] != 16'd19) @(negedge clk);
      wr(3'd0, 16'h0001);
      idle_wait(2);
      chk(oc_out, 1'b0, "R10", "zero count skipped");
      idle_wait(22);
      chk(oc_out, 1'b1, "R10", "match after wrap");

      cmp_on = 1'b0;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule